// File: doc/BRIEF.md
# Low-Order Interleaved Banked Word Memory

This block is a word-addressed store split into sixteen banks that work independently. The low four address bits pick the bank, so addresses that follow one another land in banks that follow one another. A unit that walks through memory one word at a time therefore reaches each bank only once every sixteen accesses, while the other banks are still busy with earlier work.

Requests arrive one per clock on a valid/ready handshake that carries an address, a write flag and 64 bits of write data. A bank that has just accepted an access stays busy for several clocks. A new request for that bank waits at the port, with ready held low, until the bank frees. Only a request that hits a busy bank has to wait. Each stored word also holds eight check bits, which the block computes from the write data. A read returns them unchanged beside the data after a fixed latency, so read responses come back in the order the reads were issued.

Top module: `ilv_bank_mem`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1 for every bank address.
- R2: The bank is req_addr[3:0] and the row inside the bank is req_addr[ROW_W+3:4] (ROW_W defaults to 4). Address bits above that field are ignored.
- R3: Once a bank accepts a request in cycle t, req_ready is 0 for any request to that bank in cycles t+1 to t+3, and it returns to 1 in cycle t+4 (BUSY = 4).
- R4: A request to a bank that has been idle for 4 or more cycles is accepted in the cycle it is presented, whatever the other banks are doing. A stride-1 stream is accepted at one word per clock.
- R5: Throughput depends on the stride. A stride s whose bank revisit period 16/gcd(s,16) is at least 4 streams at one word per clock. Stride 16 accepts one word every 4 clocks. Stride 8 accepts 8 words in 14 clocks.
- R6: A stalled request stays at the port with ready low until it is accepted. No later request is taken ahead of it.
- R7: A read accepted in cycle t gives rsp_valid = 1 in cycle t+4, for exactly that one response. A write produces no response.
- R8: rsp_data is the last data written to the same bank and row.
- R9: For data bit j, take p as the j-th integer in ascending order from 1 to 71 that is not a power of two. Check bit i (i = 0..6) is the XOR of every data bit j whose p has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. The check bits are stored on write and returned unchanged on rsp_check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Targeted bank is free, so the request is taken this cycle |
| req_addr | input | 24 | Word address: bank in the low bits, row above them |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| rsp_check | output | 8 | Check bits stored with the read word |

## Verification
Each result is due at a fixed cycle offset from the stimulus that causes it:
- **req_ready:** it is combinational on the current address, so the bench compares it with the cycle distance since that bank's last acceptance, in the same cycle the request is presented.
- **Read responses:** a read taken in cycle t must appear in cycle t+4. The bench schedules the expected data and check bits into a slot for that cycle.
- **Idle cycles:** every cycle without a due response must show rsp_valid low.

The bench drives inputs on the falling edge, samples just after it, and counts cycles per request. This lets stride throughput be compared with exact cycle totals.

// File: rtl/ilv_bank_mem.sv
module ilv_bank_mem #(
  parameter int NBANK  = 16,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 64,
  parameter int ROW_W  = 4,
  parameter int BUSY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic              req_we,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic [7:0]        rsp_check
);

  function automatic int hbits(input int n);
    int r;
    r = 1;
    while ((1 << r) < n + r + 1) r++;
    return r;
  endfunction

  localparam int BW     = $clog2(NBANK);
  localparam int PB     = hbits(DATA_W);
  localparam int CHK_W  = PB + 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int DEPTH  = NBANK * ROWS;
  localparam int CW     = $clog2(BUSY + 1);

  function automatic logic [CHK_W-1:0] enc(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int pos = 1; pos <= DATA_W + PB; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < PB; i++)
          if (pos[i]) c[i] = c[i] ^ d[j];
        j++;
      end
    end
    c[CHK_W-1] = ^{d, c[PB-1:0]};
    return c;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CW-1:0]     busy [NBANK];
  logic [BUSY-1:0]   pv;
  logic [WORD_W-1:0] pd [BUSY];

  wire [BW-1:0]       bank = req_addr[BW-1:0];
  wire [BW+ROW_W-1:0] idx  = {bank, req_addr[BW+ROW_W-1:BW]};
  wire                acc  = req_valid && req_ready;
  wire                unused_hi = ^req_addr[ADDR_W-1:BW+ROW_W];

  assign req_ready = (busy[bank] == '0);
  assign rsp_valid = pv[BUSY-1];
  assign rsp_data  = pd[BUSY-1][DATA_W-1:0];
  assign rsp_check = pd[BUSY-1][WORD_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) busy[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (acc && bank == b[BW-1:0]) busy[b] <= CW'(BUSY - 1);
        else if (busy[b] != '0)       busy[b] <= busy[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && req_we) mem[idx] <= {enc(req_wdata), req_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[BUSY-2:0], acc && !req_we};
  end

  always_ff @(posedge clk) begin
    pd[0] <= mem[idx];
    for (int k = 1; k < BUSY; k++) pd[k] <= pd[k-1];
  end

  logic [CW-1:0] idle_n, rquiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_n <= CW'(BUSY);
      rquiet <= CW'(BUSY);
    end else begin
      if (acc) idle_n <= '0;
      else if (idle_n != CW'(BUSY)) idle_n <= idle_n + 1'b1;
      if (acc && !req_we) rquiet <= '0;
      else if (rquiet != CW'(BUSY)) rquiet <= rquiet + 1'b1;
    end
  end

  p_conflict_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((req_valid && req_addr[BW-1:0] == $past(req_addr[BW-1:0])) |-> !req_ready))
    else $error("same-bank request accepted while bank busy");

  p_free_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_n >= CW'(BUSY - 1)) |-> req_ready)
    else $error("bank not free after busy window");

  p_rsp_has_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rquiet <= CW'(BUSY - 1)))
    else $error("response without a recent read");

  p_check_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_check == enc(rsp_data)))
    else $error("check bits do not match returned data");

endmodule

// File: tb/ilv_bank_mem_tb_top.sv
`timescale 1ns/1ps
module ilv_bank_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic        req_we;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [7:0]  rsp_check;

  ilv_bank_mem dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_check(rsp_check)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, wd = 0;
  int last [16];
  logic [63:0] mdl [256];
  logic        ev [8];
  logic [63:0] ed [8];

  function automatic logic [7:0] ecc(input logic [63:0] d);
    logic [7:0] c;
    int p;
    c = 8'h0;
    p = 0;
    for (int j = 0; j < 64; j++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      for (int i = 0; i < 7; i++)
        if ((p >> i) & 1) c[i] = c[i] ^ d[j];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [23:0] a, input logic w,
                      input logic [63:0] d, output logic accepted);
    int s;
    @(negedge clk);
    req_valid = v; req_addr = a; req_we = w; req_wdata = d;
    #0.5;
    s = cyc % 8;
    chk("R7 rsp_valid", {63'h0, rsp_valid}, {63'h0, ev[s]});
    if (ev[s] && rsp_valid) begin
      chk("R8 rsp_data", rsp_data, ed[s]);
      chk("R9 rsp_check", {56'h0, rsp_check}, {56'h0, ecc(ed[s])});
    end
    ev[s] = 1'b0;
    chk("R3/R4 req_ready", {63'h0, req_ready}, {63'h0, (cyc - last[a[3:0]]) >= 4});
    accepted = v && req_ready;
    if (accepted) begin
      last[a[3:0]] = cyc;
      if (w) mdl[a[7:0]] = d;
      else begin
        ev[(cyc + 4) % 8] = 1'b1;
        ed[(cyc + 4) % 8] = mdl[a[7:0]];
      end
    end
    cyc++;
  endtask

  task automatic send(input logic [23:0] a, input logic w, input logic [63:0] d, output int n);
    logic acc;
    n = 0;
    acc = 1'b0;
    while (!acc) begin
      step(1'b1, a, w, d, acc);
      n++;
      if (!acc) chk("R6 held request not overtaken", {63'h0, req_valid}, 64'h1);
    end
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, 24'h0, 1'b0, 64'h0, acc);
  endtask

  task automatic stride_run(input int start, input int s, input int n, input int exp_cyc, input string req);
    int tot, k;
    tot = 0;
    idle(4);
    for (int i = 0; i < n; i++) begin
      send(24'((start + i * s) & 255), 1'b0, 64'h0, k);
      tot += k;
    end
    chk(req, 64'(tot), 64'(exp_cyc));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", wd);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int tot, k;
    logic acc;
    logic [31:0] seed;
    for (int b = 0; b < 16; b++) last[b] = -100;
    for (int i = 0; i < 8; i++) ev[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      req_addr = 24'(b);
      #0.5;
      chk("R1 ready after reset", {63'h0, req_ready}, 64'h1);
      chk("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    end

    tot = 0;
    for (int i = 0; i < 256; i++) begin
      send(24'(i) | 24'hA5_0000, 1'b1, {32'(i) * 32'h9E37_79B9, ~32'(i) ^ 32'h0F0F_1234}, k);
      tot += k;
    end
    chk("R4 stride-1 writes one per clock", 64'(tot), 64'd256);

    tot = 0;
    for (int i = 0; i < 256; i++) begin
      send(24'(i), 1'b0, 64'h0, k);
      tot += k;
    end
    chk("R2 stride-1 readback one per clock", 64'(tot), 64'd256);

    stride_run(3, 16, 8, 29, "R5 stride 16 cycles");
    stride_run(5, 8, 8, 14, "R5 stride 8 cycles");
    stride_run(0, 4, 16, 16, "R5 stride 4 cycles");
    stride_run(1, 3, 32, 32, "R5 stride 3 cycles");
    stride_run(2, 2, 32, 32, "R5 stride 2 cycles");

    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send({seed[31:24], 8'h00, seed[23:16]}, seed[5], {seed, seed ^ 32'hDEAD_BEEF}, k);
      if (seed[9]) idle(1);
    end

    for (int i = 0; i < 16; i++) begin
      step(1'b0, 24'h0, 1'b0, 64'h0, acc);
    end
    chk("R7 no pending response at end", 64'(ev[0] | ev[1] | ev[2] | ev[3]), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule